// File: doc/BRIEF.md
# CPU Clock Pair Stop and Power-Down Sequencer

This block decides, for each differential CPU clock output pair, what the pair's two legs should do while the system asks for clock stop or power-down. The output buffers themselves are current-mode analog drivers and sit outside this block. Here each leg's behaviour is a 2-bit drive code, and a buffer downstream turns that code into a waveform or a held level. The block runs on the free-running CPU clock. It also brings out `ref_level`, a half-rate level that stands for the toggling waveform, so that entry into and exit from the held states can be placed on a clean edge.

Two active-low requests drive the block. The stop request is asynchronous and goes through a two-flop synchronizer. The power-down request counts only after two consecutive low samples. Two mode bits choose what a held pair looks like: `stop_float` applies while stopped and `pdn_float` applies while powered down. Each pair has a `free_run` bit that exempts it from stop but not from power-down.

Each pair runs its own state machine with these states:
- PS_RUN: toggling.
- PS_HALT: stopped.
- PS_PDOWN: powered down.
- PS_WAKE: one cycle of prompt high drive after a floating hold.
- PS_RESYNC: a counted high hold before toggling resumes.

These transitions are named:
- halt_entry: PS_RUN to PS_HALT.
- halt_exit: PS_HALT to PS_WAKE or PS_RESYNC.
- pdn_entry: any state to PS_PDOWN.
- pdn_exit: PS_PDOWN to PS_HALT, PS_WAKE or PS_RESYNC.
- wake_done: PS_WAKE to PS_RESYNC.
- resync_done: PS_RESYNC to PS_RUN.
- restop: PS_WAKE or PS_RESYNC back to PS_HALT.

Top module: `ccs_stop_ctrl`

## Requirements
- R1: While reset is held, and right after it, every pair shows true code 00 and complement code 00, and `ref_level` is 0. After reset `ref_level` inverts on every clock edge.
- R2: `stop_req_n` passes through two flops before it is used. A running stoppable pair takes halt_entry only at an edge where the synchronized request is active and `ref_level` is 1, so a high half-period is extended and never cut short.
- R3: A pair in PS_HALT with `stop_float`=0 shows true code 10 (high at six times the reference current) and complement code 11 (low, not driven).
- R4: A pair in PS_HALT with `stop_float`=1 shows true code 11 and complement code 11 (both legs undriven).
- R5: On the way back to toggling, a pair holds true 10 / complement 11 in PS_RESYNC for RESUME_CYC clock cycles. It then takes resync_done at the first later edge where `ref_level` is 1.
- R6: Power-down is qualified when `pdn_req_n` is sampled low on two consecutive rising edges, and every pair enters PS_PDOWN on the following edge. A single low sample has no effect.
- R7: In PS_PDOWN, with `pdn_float`=0, the true code is 01 (high at twice the reference current) and the complement code is 11. With `pdn_float`=1 both codes are 11. This applies to free-running and stoppable pairs alike, and power-down takes priority over stop.
- R8: A pair with `free_run`=1 never takes halt_entry and keeps toggling (codes 00/00) while only a stop is requested.
- R9: When a pair leaves a floating hold (halt with `stop_float`=1, or power-down with `pdn_float`=1), it spends one cycle in PS_WAKE showing true 10 / complement 11 before it enters PS_RESYNC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low clock stop request |
| pdn_req_n | input | 1 | Active-low power-down request |
| stop_float | input | 1 | Stopped look: 0 = true leg high at 6x, 1 = both legs undriven |
| pdn_float | input | 1 | Power-down look: 0 = true leg high at 2x, 1 = both legs undriven |
| free_run | input | NPAIR | Per pair: 1 = exempt from stop |
| ref_level | output | 1 | Half-rate level that stands for the toggling waveform |
| true_code | output | 2*NPAIR | Per-pair true-leg drive code, pair i at bits [2i+1:2i] |
| comp_code | output | 2*NPAIR | Per-pair complement-leg drive code, pair i at bits [2i+1:2i] |

## Verification
Every result has a fixed latency counted from the rising edge that samples a stimulus:
- A change of `stop_req_n` reaches the state machines after two edges, and the drive codes change at the third edge, or at the fourth when `ref_level` is low.
- A power-down request shows at the third edge after its first low sample.
- Mode-bit changes show at once on held pairs.

The bench drives inputs just after the falling edge and advances a cycle-level reference model on the rising edge. It compares every pair at the next falling edge, so each comparison sees exactly the registers that have updated. The directed checks are placed at these counted falling edges: the edge just before a change is due and the edge on which it is due.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

    typedef enum logic [1:0] {
        DRV_TOGGLE = 2'b00,
        DRV_HI_X2  = 2'b01,
        DRV_HI_X6  = 2'b10,
        DRV_OFF    = 2'b11
    } drv_code_t;

    typedef enum logic [2:0] {
        PS_RUN    = 3'd0,
        PS_HALT   = 3'd1,
        PS_PDOWN  = 3'd2,
        PS_WAKE   = 3'd3,
        PS_RESYNC = 3'd4
    } pair_state_t;

endpackage

// File: rtl/ccs_req_filter.sv
// Shift register over an active-low request. Either the last stage is used
// (synchronizer) or all stages must agree (consecutive-sample qualifier).
module ccs_req_filter #(
    parameter int STAGES      = 2,
    parameter bit REQUIRE_ALL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    output logic req_act
);

    logic [STAGES-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[STAGES-2:0], ~req_n};
    end

    generate
        if (REQUIRE_ALL) begin : g_all
            always_comb req_act = &hist_q;
        end else begin : g_last
            always_comb req_act = hist_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/ccs_pair_fsm.sv
module ccs_pair_fsm
    import ccs_pkg::*;
#(
    parameter int RESUME_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       phase,
    input  logic       stop_act,
    input  logic       pdn_act,
    input  logic       stop_float,
    input  logic       pdn_float,
    input  logic       free_run,
    output logic [1:0] true_code,
    output logic [1:0] comp_code
);

    localparam int          CNT_W = (RESUME_CYC > 2) ? $clog2(RESUME_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(RESUME_CYC - 1);

    pair_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             halt_ok;

    assign halt_ok = stop_act && !free_run;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (pdn_act) begin
            state_d = PS_PDOWN;                       // pdn_entry
        end else begin
            unique case (state_q)
                PS_RUN: begin
                    if (halt_ok && phase) state_d = PS_HALT;   // halt_entry
                end
                PS_HALT: begin
                    if (!halt_ok) begin                       // halt_exit
                        if (stop_float) state_d = PS_WAKE;
                        else begin
                            state_d = PS_RESYNC;
                            cnt_d   = LOAD;
                        end
                    end
                end
                PS_PDOWN: begin                               // pdn_exit
                    if (halt_ok)        state_d = PS_HALT;
                    else if (pdn_float) state_d = PS_WAKE;
                    else begin
                        state_d = PS_RESYNC;
                        cnt_d   = LOAD;
                    end
                end
                PS_WAKE: begin
                    if (halt_ok) state_d = PS_HALT;           // restop
                    else begin
                        state_d = PS_RESYNC;                  // wake_done
                        cnt_d   = LOAD;
                    end
                end
                PS_RESYNC: begin
                    if (halt_ok)            state_d = PS_HALT; // restop
                    else if (cnt_q != '0)   cnt_d   = cnt_q - 1'b1;
                    else if (phase)         state_d = PS_RUN;  // resync_done
                end
                default: state_d = PS_RUN;
            endcase
        end
    end

    // outputs
    always_comb begin
        true_code = DRV_TOGGLE;
        comp_code = DRV_TOGGLE;
        unique case (state_q)
            PS_RUN: begin
                true_code = DRV_TOGGLE;
                comp_code = DRV_TOGGLE;
            end
            PS_HALT: begin
                true_code = stop_float ? DRV_OFF : DRV_HI_X6;
                comp_code = DRV_OFF;
            end
            PS_PDOWN: begin
                true_code = pdn_float ? DRV_OFF : DRV_HI_X2;
                comp_code = DRV_OFF;
            end
            PS_WAKE, PS_RESYNC: begin
                true_code = DRV_HI_X6;
                comp_code = DRV_OFF;
            end
            default: begin
                true_code = DRV_TOGGLE;
                comp_code = DRV_TOGGLE;
            end
        endcase
    end

endmodule

// File: rtl/ccs_stop_ctrl.sv
module ccs_stop_ctrl #(
    parameter int NPAIR      = 3,
    parameter int RESUME_CYC = 2,
    parameter int SYNC_STG   = 2,
    parameter int PDN_SMP    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stop_req_n,
    input  logic               pdn_req_n,
    input  logic               stop_float,
    input  logic               pdn_float,
    input  logic [NPAIR-1:0]   free_run,
    output logic               ref_level,
    output logic [2*NPAIR-1:0] true_code,
    output logic [2*NPAIR-1:0] comp_code
);

    logic phase_q;
    logic stop_act;
    logic pdn_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end
    assign ref_level = phase_q;

    ccs_req_filter #(.STAGES(SYNC_STG), .REQUIRE_ALL(1'b0)) u_stop_sync (
        .clk(clk), .rst_n(rst_n), .req_n(stop_req_n), .req_act(stop_act)
    );

    ccs_req_filter #(.STAGES(PDN_SMP), .REQUIRE_ALL(1'b1)) u_pdn_qual (
        .clk(clk), .rst_n(rst_n), .req_n(pdn_req_n), .req_act(pdn_act)
    );

    generate
        for (genvar i = 0; i < NPAIR; i++) begin : g_pair
            ccs_pair_fsm #(.RESUME_CYC(RESUME_CYC)) u_fsm (
                .clk       (clk),
                .rst_n     (rst_n),
                .phase     (phase_q),
                .stop_act  (stop_act),
                .pdn_act   (pdn_act),
                .stop_float(stop_float),
                .pdn_float (pdn_float),
                .free_run  (free_run[i]),
                .true_code (true_code[2*i+1:2*i]),
                .comp_code (comp_code[2*i+1:2*i])
            );
        end
    endgenerate

endmodule

// File: rtl/ccs_stop_ctrl_chk.sv
module ccs_stop_ctrl_chk #(
    parameter int NPAIR = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pdn_req_n,
    input logic               pdn_act,
    input logic [NPAIR-1:0]   free_run,
    input logic               ref_level,
    input logic [2*NPAIR-1:0] true_code,
    input logic [2*NPAIR-1:0] comp_code
);

    // R1
    phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_level |=> !ref_level);

    // R6
    pdn_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pdn_act |-> (!$past(pdn_req_n) && !$past(pdn_req_n, 2)));

    generate
        for (genvar i = 0; i < NPAIR; i++) begin : g_chk
            // R7
            pdn_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pdn_act |=> ((true_code[2*i+1:2*i] == 2'b01 || true_code[2*i+1:2*i] == 2'b11)
                             && comp_code[2*i+1:2*i] == 2'b11));
            // R2
            halt_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (true_code[2*i+1:2*i] == 2'b00 && !ref_level && !pdn_act)
                |=> true_code[2*i+1:2*i] == 2'b00);
            // R8
            free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (true_code[2*i+1:2*i] == 2'b00 && free_run[i] && !pdn_act)
                |=> true_code[2*i+1:2*i] == 2'b00);
            // R3
            comp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (true_code[2*i+1:2*i] != 2'b00) |-> comp_code[2*i+1:2*i] == 2'b11);
        end
    endgenerate

endmodule

bind ccs_stop_ctrl ccs_stop_ctrl_chk #(.NPAIR(NPAIR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pdn_req_n (pdn_req_n),
    .pdn_act   (pdn_act),
    .free_run  (free_run),
    .ref_level (ref_level),
    .true_code (true_code),
    .comp_code (comp_code)
);

// File: tb/sim_ccs_stop_ctrl.sv
module sim_ccs_stop_ctrl;

    localparam int NP = 3;
    localparam int RC = 2;

    localparam int S_RUN = 0, S_HALT = 1, S_PDOWN = 2, S_WAKE = 3, S_RESYNC = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            stop_req_n = 1'b1;
    logic            pdn_req_n = 1'b1;
    logic            stop_float = 1'b0;
    logic            pdn_float = 1'b0;
    logic [NP-1:0]   free_run = '0;
    logic            ref_level;
    logic [2*NP-1:0] true_code;
    logic [2*NP-1:0] comp_code;

    int n_chk = 0;
    int n_bad = 0;
    bit stream_on = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ccs_stop_ctrl #(.NPAIR(NP), .RESUME_CYC(RC)) u0 (
        .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n), .pdn_req_n(pdn_req_n),
        .stop_float(stop_float), .pdn_float(pdn_float), .free_run(free_run),
        .ref_level(ref_level), .true_code(true_code), .comp_code(comp_code)
    );

    // ---------------- reference model ----------------
    typedef struct packed { logic [3:0] st; logic [3:0] cnt; } mstep_t;

    logic       m_phase;
    logic [1:0] m_ss, m_pp;
    int         m_st  [NP];
    int         m_cnt [NP];

    function automatic mstep_t step_fn(int st, int cnt, bit stop_on, bit pdn_on,
                                       bit ph, bit fr, bit sf, bit pf);
        mstep_t r;
        bit hok;
        hok   = stop_on && !fr;
        r.st  = 4'(st);
        r.cnt = 4'(cnt);
        if (pdn_on) r.st = 4'(S_PDOWN);
        else case (st)
            S_RUN:    if (hok && ph) r.st = 4'(S_HALT);
            S_HALT:   if (!hok) begin
                          if (sf) r.st = 4'(S_WAKE);
                          else begin r.st = 4'(S_RESYNC); r.cnt = 4'(RC - 1); end
                      end
            S_PDOWN:  if (hok) r.st = 4'(S_HALT);
                      else if (pf) r.st = 4'(S_WAKE);
                      else begin r.st = 4'(S_RESYNC); r.cnt = 4'(RC - 1); end
            S_WAKE:   if (hok) r.st = 4'(S_HALT);
                      else begin r.st = 4'(S_RESYNC); r.cnt = 4'(RC - 1); end
            S_RESYNC: if (hok) r.st = 4'(S_HALT);
                      else if (cnt != 0) r.cnt = 4'(cnt - 1);
                      else if (ph) r.st = 4'(S_RUN);
            default:  r.st = 4'(S_RUN);
        endcase
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase <= 1'b0;
            m_ss    <= 2'b00;
            m_pp    <= 2'b00;
            for (int i = 0; i < NP; i++) begin
                m_st[i]  <= S_RUN;
                m_cnt[i] <= 0;
            end
        end else begin
            m_phase <= ~m_phase;
            m_ss    <= {m_ss[0], ~stop_req_n};
            m_pp    <= {m_pp[0], ~pdn_req_n};
            for (int i = 0; i < NP; i++) begin
                mstep_t s;
                s = step_fn(m_st[i], m_cnt[i], m_ss[1], &m_pp, m_phase,
                            free_run[i], stop_float, pdn_float);
                m_st[i]  <= int'(s.st);
                m_cnt[i] <= int'(s.cnt);
            end
        end
    end

    function automatic logic [1:0] exp_t(int st);
        case (st)
            S_RUN:   return 2'b00;
            S_HALT:  return stop_float ? 2'b11 : 2'b10;
            S_PDOWN: return pdn_float ? 2'b11 : 2'b01;
            default: return 2'b10;
        endcase
    endfunction

    function automatic logic [1:0] exp_c(int st);
        return (st == S_RUN) ? 2'b00 : 2'b11;
    endfunction

    function automatic string tag_of(int st);
        case (st)
            S_RUN:    return "R2";
            S_HALT:   return stop_float ? "R4" : "R3";
            S_PDOWN:  return "R7";
            S_WAKE:   return "R9";
            default:  return "R5";
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // stream comparison against the model at every falling edge
    always @(negedge clk) begin
        if (stream_on && rst_n) begin
            check("R1", {7'd0, ref_level}, {7'd0, m_phase});
            for (int i = 0; i < NP; i++) begin
                check(tag_of(m_st[i]),
                      {4'd0, true_code[2*i+:2], comp_code[2*i+:2]},
                      {4'd0, exp_t(m_st[i]), exp_c(m_st[i])});
            end
        end
    end

    // watchdog
    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0000_5eed));
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", {2'b0, ref_level, true_code[1:0], comp_code[1:0], 1'b0},
                    8'h00);
        check("R1", {2'b0, true_code}, 8'h00);
        check("R1", {2'b0, comp_code}, 8'h00);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1", {7'd0, ref_level}, 8'h01);
        @(negedge clk);
        check("R1", {7'd0, ref_level}, 8'h00);
        stream_on = 1'b1;

        // R2/R3/R8: pair0 free-running, stop with driven-high look
        #1 free_run = 3'b001; stop_float = 1'b0; stop_req_n = 1'b0;
        @(negedge clk);
        check("R2", {6'd0, true_code[3:2]}, 8'h00);   // sync not through yet
        repeat (6) @(negedge clk);
        check("R3", {4'd0, true_code[3:2], comp_code[3:2]}, 8'h0B);
        check("R8", {4'd0, true_code[1:0], comp_code[1:0]}, 8'h00);
        #1 stop_req_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R5", {4'd0, true_code[3:2], comp_code[3:2]}, 8'h00);

        // R4/R9: floating stop look, then prompt wake
        #1 stop_float = 1'b1; stop_req_n = 1'b0;
        repeat (7) @(negedge clk);
        check("R4", {4'd0, true_code[5:4], comp_code[5:4]}, 8'h0F);
        #1 stop_req_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", {4'd0, true_code[5:4], comp_code[5:4]}, 8'h0B);
        repeat (10) @(negedge clk);
        check("R5", {2'd0, true_code}, 8'h00);

        // R6: single low sample ignored
        #1 stop_float = 1'b0; pdn_float = 1'b0; pdn_req_n = 1'b0;
        @(negedge clk);
        #1 pdn_req_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check("R6", {2'd0, true_code}, 8'h00);
        end
        // R6/R7: qualified power-down hits every pair, free-running included
        #1 pdn_req_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R6", {2'd0, true_code}, 8'h00);
        @(negedge clk);
        check("R7", {2'd0, true_code}, 8'h15);
        check("R7", {2'd0, comp_code}, 8'h3F);
        #1 pdn_float = 1'b1;
        @(negedge clk);
        check("R7", {2'd0, true_code}, 8'h3F);
        #1 pdn_req_n = 1'b1;
        repeat (12) @(negedge clk);

        // constrained random phase
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            #1;
            if ($urandom_range(11, 0) == 0) stop_req_n = ~stop_req_n;
            if ($urandom_range(29, 0) == 0) pdn_req_n  = ~pdn_req_n;
            if ($urandom_range(49, 0) == 0) stop_float = ~stop_float;
            if ($urandom_range(49, 0) == 0) pdn_float  = ~pdn_float;
            if ($urandom_range(79, 0) == 0) free_run   = NP'($urandom_range(7, 0));
        end

        @(negedge clk);
        stream_on = 1'b0;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule